// File: doc/BRIEF.md
# Absmean Ternary Weight Quantizer

This block turns a matrix of signed fixed-point weights into ternary codes. The threshold is not fixed. It comes from the matrix itself. In a first pass the block reads every weight through an external read port and sums the magnitudes. The sum, divided by the element count, gives a per-tensor scale. In a second pass it reads the weights again and emits one two-bit code per weight, in address order. The scale stays on an output port, so that a later stage can multiply integer accumulations by it.

The block does not divide each weight. It compares twice the magnitude of the weight with the scale. When that doubled magnitude reaches the scale, the code is the sign of the weight; otherwise the code is zero. This gives rounding to the nearest integer with ties going away from zero, followed by a clip to three levels. The element count is a power of two, so the mean is a right shift. The scale is forced to at least one LSB, which plays the role of the small guard term in the divisor.

The read port has a fixed latency set by a parameter. A single start pulse runs both passes, and a done pulse closes the run.

Top module: `tern_absmean_quant`

## Requirements
- R1: After reset, busy, done, code_valid and rd_req are low and scale reads 0.
- R2: A start pulse while idle makes the block request every address 0 to N-1 (N = 2^N_LOG2) once in ascending order, one per cycle, for the first pass, and then again for the second pass, which is 2N requests per run. Read data is taken RD_LAT cycles after its request, and no request is made while busy is low.
- R3: scale equals floor(sum of |w| / N), where |-2^(W_BITS-1)| counts as 2^(W_BITS-1). It is forced to 1 when that floor is 0. It updates when the first pass ends and holds until the first pass of the next run ends.
- R4: The code of weight w is sign(w) when 2·|w| ≥ scale and zero otherwise, so an exact tie gives ±1.
- R5: The code encoding is 2'b00 for zero, 2'b01 for +1 and 2'b11 for -1, and 2'b10 never appears.
- R6: Each run gives exactly N code_valid pulses, one per weight, in address order, with code_idx equal to the weight's address.
- R7: done is a single-cycle pulse in the cycle right after the last code_valid, and busy is low from the next cycle on.
- R8: A start pulse while busy, including the done cycle, is ignored: the run in progress is unchanged and no extra reads are made.
- R9: An all-zero matrix gives scale 1 and all-zero codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| rd_req | output | 1 | Weight read request |
| rd_addr | output | N_LOG2 | Weight read address |
| rd_data | input | W_BITS | Signed weight, valid RD_LAT cycles after its request |
| code_valid | output | 1 | Marks a ternary code |
| code | output | 2 | Ternary code (00 zero, 01 plus one, 11 minus one) |
| code_idx | output | N_LOG2 | Address of the coded weight |
| scale | output | W_BITS | Per-tensor mean magnitude, at least 1 after a run |
| busy | output | 1 | High from the cycle after an accepted start through the done cycle |
| done | output | 1 | End-of-run pulse |

## Verification
Two events can fall in the same cycle: a new start request and the done pulse of the run that is finishing. Two other events can also meet: a start request and the reads of the first pass. The bench raises start in exactly the cycle where it sees done high. In another run it raises start in the middle of the first pass. In both cases it judges the outcome by the total read-request count staying at 2N, by busy staying low after done, and by the codes and scale matching values computed from the weights. Ties on the rounding boundary, the most negative weight and an all-zero matrix are each run as their own matrix.

// File: rtl/tq_pkg.sv
package tq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SUM,
      ST_MEAN,
      ST_EMIT,
      ST_FLUSH,
      ST_DONE
   } tq_state_e;

   localparam logic [1:0] CODE_ZERO = 2'b00;
   localparam logic [1:0] CODE_POS  = 2'b01;
   localparam logic [1:0] CODE_NEG  = 2'b11;

endpackage

// File: rtl/tq_rd_seq.sv
module tq_rd_seq #(
   parameter int N_LOG2 = 4,
   parameter int RD_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   output logic              rd_req,
   output logic [N_LOG2-1:0] rd_addr,
   output logic              ret_vld,
   output logic [N_LOG2-1:0] ret_idx,
   output logic              ret_last
);

   localparam logic [N_LOG2-1:0] LAST_IDX = '1;

   logic              active_q;
   logic [N_LOG2-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (go) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
      end else if (active_q) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == LAST_IDX) active_q <= 1'b0;
      end
   end

   assign rd_req  = active_q;
   assign rd_addr = cnt_q;

   generate
      if (RD_LAT == 0) begin : g_comb_ret
         assign ret_vld = rd_req;
         assign ret_idx = rd_addr;
      end else begin : g_pipe_ret
         logic [RD_LAT-1:0]             vld_sr;
         logic [RD_LAT-1:0][N_LOG2-1:0] idx_sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_sr <= '0;
               idx_sr <= '0;
            end else begin
               for (int i = RD_LAT - 1; i > 0; i--) begin
                  vld_sr[i] <= vld_sr[i-1];
                  idx_sr[i] <= idx_sr[i-1];
               end
               vld_sr[0] <= rd_req;
               idx_sr[0] <= rd_addr;
            end
         end
         assign ret_vld = vld_sr[RD_LAT-1];
         assign ret_idx = idx_sr[RD_LAT-1];
      end
   endgenerate

   assign ret_last = ret_vld && (ret_idx == LAST_IDX);

   // R2
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && $past(rd_req)) |-> (rd_addr == $past(rd_addr) + 1'b1));

   // R8
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !active_q);

endmodule

// File: rtl/tq_abs_acc.sv
module tq_abs_acc #(
   parameter int W_BITS = 16,
   parameter int N_LOG2 = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     en,
   input  logic signed [W_BITS-1:0] din,
   output logic        [W_BITS-1:0] mean
);

   localparam int SUM_W = W_BITS + N_LOG2;

   logic [W_BITS-1:0] mag;
   logic [SUM_W-1:0]  sum_q;

   assign mag = din[W_BITS-1] ? W_BITS'(-din) : W_BITS'(din);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sum_q <= '0;
      else if (clr) sum_q <= '0;
      else if (en)  sum_q <= sum_q + SUM_W'(mag);
   end

   assign mean = sum_q[SUM_W-1:N_LOG2];

   // R3
   acc_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr) |=> (sum_q >= $past(sum_q)));

endmodule

// File: rtl/tq_coder.sv
module tq_coder
   import tq_pkg::*;
#(
   parameter int W_BITS = 16,
   parameter int N_LOG2 = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en,
   input  logic signed [W_BITS-1:0] din,
   input  logic        [N_LOG2-1:0] idx,
   input  logic        [W_BITS-1:0] scale,
   output logic                     vld_q,
   output logic        [1:0]        code_q,
   output logic        [N_LOG2-1:0] idx_q
);

   logic [W_BITS-1:0] mag;
   logic              hit;

   assign mag = din[W_BITS-1] ? W_BITS'(-din) : W_BITS'(din);
   assign hit = {mag, 1'b0} >= {1'b0, scale};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         code_q <= CODE_ZERO;
         idx_q  <= '0;
      end else begin
         vld_q <= en;
         if (en) begin
            idx_q  <= idx;
            code_q <= hit ? (din[W_BITS-1] ? CODE_NEG : CODE_POS) : CODE_ZERO;
         end
      end
   end

   // R5
   code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> (code_q != 2'b10));

   // R4
   zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (din == '0)) |=> (code_q == CODE_ZERO));

endmodule

// File: rtl/tern_absmean_quant.sv
module tern_absmean_quant
   import tq_pkg::*;
#(
   parameter int W_BITS = 16,
   parameter int N_LOG2 = 4,
   parameter int RD_LAT = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   output logic                     rd_req,
   output logic        [N_LOG2-1:0] rd_addr,
   input  logic signed [W_BITS-1:0] rd_data,
   output logic                     code_valid,
   output logic        [1:0]        code,
   output logic        [N_LOG2-1:0] code_idx,
   output logic        [W_BITS-1:0] scale,
   output logic                     busy,
   output logic                     done
);

   generate
      if (W_BITS < 2 || W_BITS > 32) begin : g_bad_width
         $error("W_BITS must lie in 2..32");
      end
      if (N_LOG2 < 1 || N_LOG2 > 20) begin : g_bad_count
         $error("N_LOG2 must lie in 1..20");
      end
      if (RD_LAT < 0 || RD_LAT > 8) begin : g_bad_lat
         $error("RD_LAT must lie in 0..8");
      end
   endgenerate

   tq_state_e         st_q;
   logic              seq_go;
   logic              acc_clr;
   logic              acc_en;
   logic              cod_en;
   logic              ret_vld;
   logic              ret_last;
   logic [N_LOG2-1:0] ret_idx;
   logic [W_BITS-1:0] mean_raw;
   logic [W_BITS-1:0] scale_q;

   assign busy    = (st_q != ST_IDLE);
   assign done    = (st_q == ST_DONE);
   assign acc_clr = (st_q == ST_IDLE) && start;
   assign seq_go  = acc_clr || (st_q == ST_MEAN);
   assign acc_en  = (st_q == ST_SUM) && ret_vld;
   assign cod_en  = (st_q == ST_EMIT) && ret_vld;
   assign scale   = scale_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         scale_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE:  if (start) st_q <= ST_SUM;
            ST_SUM:   if (ret_last) st_q <= ST_MEAN;
            ST_MEAN: begin
               scale_q <= (mean_raw == '0) ? W_BITS'(1) : mean_raw;
               st_q    <= ST_EMIT;
            end
            ST_EMIT:  if (ret_last) st_q <= ST_FLUSH;
            ST_FLUSH: st_q <= ST_DONE;
            ST_DONE:  st_q <= ST_IDLE;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   tq_rd_seq #(
      .N_LOG2 (N_LOG2),
      .RD_LAT (RD_LAT)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (seq_go),
      .rd_req   (rd_req),
      .rd_addr  (rd_addr),
      .ret_vld  (ret_vld),
      .ret_idx  (ret_idx),
      .ret_last (ret_last)
   );

   tq_abs_acc #(
      .W_BITS (W_BITS),
      .N_LOG2 (N_LOG2)
   ) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (acc_clr),
      .en    (acc_en),
      .din   (rd_data),
      .mean  (mean_raw)
   );

   tq_coder #(
      .W_BITS (W_BITS),
      .N_LOG2 (N_LOG2)
   ) u_cod (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (cod_en),
      .din    (rd_data),
      .idx    (ret_idx),
      .scale  (scale_q),
      .vld_q  (code_valid),
      .code_q (code),
      .idx_q  (code_idx)
   );

   // R7
   done_after_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(code_valid));

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rd_req);

   // R3
   scale_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      code_valid |-> (scale != '0));

   // R8
   done_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

endmodule

// File: tb/sim_tern_absmean_quant.sv
module sim_tern_absmean_quant;

   localparam int WB = 16;
   localparam int NL = 4;
   localparam int NW = 1 << NL;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 start = 1'b0;
   logic                 rd_req;
   logic        [NL-1:0] rd_addr;
   logic signed [WB-1:0] rd_data = '0;
   logic                 code_valid;
   logic        [1:0]    code;
   logic        [NL-1:0] code_idx;
   logic        [WB-1:0] scale;
   logic                 busy;
   logic                 done;

   int wmem [NW];
   int nchk = 0;
   int nfail = 0;
   int cyc = 0;
   int req_cnt = 0, addr_err = 0, ncode = 0, idx_err = 0, bad_code = 0;
   int done_cnt = 0, done_cyc = 0, last_code_cyc = 0;
   logic [1:0] got [NW];

   always #10 clk = ~clk;

   tern_absmean_quant #(.W_BITS(WB), .N_LOG2(NL), .RD_LAT(1)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_data(rd_data), .code_valid(code_valid), .code(code), .code_idx(code_idx),
      .scale(scale), .busy(busy), .done(done)
   );

   // memory model with one cycle of read latency
   always @(posedge clk) rd_data <= 16'(wmem[rd_addr]);
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rd_req) begin
         if (int'(rd_addr) != (req_cnt % NW)) addr_err++;
         req_cnt++;
      end
      if (code_valid) begin
         if (ncode < NW) begin
            got[ncode] = code;
            if (int'(code_idx) != ncode) idx_err++;
         end
         if (code == 2'b10) bad_code++;
         last_code_cyc = cyc;
         ncode++;
      end
      if (done) begin
         done_cnt++;
         done_cyc = cyc;
      end
   end

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   function automatic int exp_scale();
      longint s = 0;
      for (int i = 0; i < NW; i++) s += (wmem[i] < 0) ? -wmem[i] : wmem[i];
      s = s / NW;
      if (s == 0) s = 1;
      return int'(s);
   endfunction

   function automatic logic [1:0] exp_code(int w, int sc);
      int a = (w < 0) ? -w : w;
      if (2 * a >= sc) return (w < 0) ? 2'b11 : 2'b01;
      return 2'b00;
   endfunction

   // mode 0: plain, 1: start during pass one, 2: start in the done cycle
   task automatic run_case(input string name, input int mode);
      int t = 0;
      int sc;
      req_cnt = 0; addr_err = 0; ncode = 0; idx_err = 0; bad_code = 0; done_cnt = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      if (mode == 1) begin
         repeat (5) @(negedge clk);
         start = 1'b1;
         @(negedge clk) start = 1'b0;
      end
      while (!done && t < 2000) begin
         @(negedge clk);
         t++;
      end
      chk(t < 2000, "R7", {name, " done seen"}, t, 2000);
      if (mode == 2) begin
         start = 1'b1;
         @(negedge clk) start = 1'b0;
      end
      repeat (4) @(negedge clk);
      sc = exp_scale();
      // R2
      chk(req_cnt == 2 * NW, "R2", {name, " request count"}, req_cnt, 2 * NW);
      chk(addr_err == 0, "R2", {name, " address order errors"}, addr_err, 0);
      // R3
      chk(int'(scale) == sc, "R3", {name, " scale"}, scale, sc);
      // R6
      chk(ncode == NW, "R6", {name, " code count"}, ncode, NW);
      chk(idx_err == 0, "R6", {name, " code_idx errors"}, idx_err, 0);
      // R5
      chk(bad_code == 0, "R5", {name, " illegal codes"}, bad_code, 0);
      // R7
      chk(done_cnt == 1, "R7", {name, " done pulses"}, done_cnt, 1);
      chk(done_cyc == last_code_cyc + 1, "R7", {name, " done timing"}, done_cyc, last_code_cyc + 1);
      // R8
      chk(busy == 1'b0, "R8", {name, " busy after run"}, busy, 0);
      // R4
      for (int i = 0; i < NW; i++) begin
         logic [1:0] e = exp_code(wmem[i], sc);
         chk(got[i] == e, "R4", {name, " code"}, got[i], e);
      end
   endtask

   task automatic test_reset();
      // R1
      chk(!busy && !done && !code_valid && !rd_req, "R1", "control outputs low", busy, 0);
      chk(scale == '0, "R1", "scale at reset", scale, 0);
   endtask

   task automatic test_mixed();
      for (int i = 0; i < NW; i++) wmem[i] = (i * 977) % 4001 - 2000;
      run_case("mixed", 0);
   endtask

   task automatic test_ties();
      wmem[0] = 3; wmem[1] = -3; wmem[2] = 2; wmem[3] = -2; wmem[4] = 9;
      for (int i = 5; i < NW; i++) wmem[i] = (i % 2 == 0) ? 7 : -7;
      run_case("ties R4", 0);
   endtask

   task automatic test_zero();
      for (int i = 0; i < NW; i++) wmem[i] = 0;
      run_case("zero R9", 0);
      chk(scale == 16'd1, "R9", "zero matrix scale", scale, 1);
   endtask

   task automatic test_min_neg();
      for (int i = 0; i < NW; i++) wmem[i] = -32768;
      run_case("most negative", 0);
      chk(scale == 16'd32768, "R3", "most negative scale", scale, 32768);
   endtask

   task automatic test_outlier();
      for (int i = 0; i < NW; i++) wmem[i] = (i % 3 == 0) ? -1 : 1;
      wmem[7] = 30000;
      run_case("outlier", 0);
   endtask

   task automatic test_start_busy();
      for (int i = 0; i < NW; i++) wmem[i] = 100 - 13 * i;
      run_case("start while busy R8", 1);
   endtask

   task automatic test_start_done();
      for (int i = 0; i < NW; i++) wmem[i] = (i % 4) * 50 - 60;
      run_case("start in done cycle R8", 2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      test_mixed();
      test_ties();
      test_zero();
      test_min_neg();
      test_outlier();
      test_start_busy();
      test_start_done();
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule